// File: doc/BRIEF.md
# NAND Sequential Cache-Read Sequencer

This block sits on the controller side of a raw NAND flash interface. It accepts one read request at a time, given as a start page, a column offset inside that page and a byte length. It turns that request into the byte-wide bus traffic the flash expects: command cycles, address cycles, waits on the ready/busy line and data-in strobes. The bytes it reads arrive in order on a simple valid/data output stream.

The block works out the flow from the geometry of the request. Short requests are served as ordinary page reads, one complete command/address/wait/data sequence for each page. Requests long enough to gain from overlap use the cache-read flow. The device loads the following page into its array register while the current page is clocked out of its cache register. Each later page then costs only one command byte and one short busy period. The final page of a cache run is closed with the cache-end opcode, so the device stops loading pages in the background. Page size, the three-row-byte option and the wait timeout are static configuration inputs. The write-to-busy and ready-to-read delays are parameters.

Top module: `nand_crd_top`

## Requirements
- R1: While reset is applied and after it is released, `bus_cle`, `bus_ale`, `bus_re`, `ack`, `err` and `out_valid` are all low.
- R2: An ordinary page read drives the command byte 0x00, then the address cycles, then the command byte 0x30. It then waits for ready and strobes the page data. Command cycles carry only 0x00, 0x30, 0x31 or 0x3F. At most one of `bus_cle`, `bus_ale` and `bus_re` is high in any cycle.
- R3: The address cycles go out in this order: column bits 7:0, column bits 15:8, row bits 7:0, row bits 15:8. When `cfg_row3` is 1, a fifth cycle follows with row bits 23:16. When `cfg_row3` is 0, exactly four cycles are sent.
- R4: The cache flow is chosen in two cases. The first is a column of 0 with a length of at least twice the page size. The second is a nonzero column where column plus length is at least three times the page size. Every other request uses ordinary reads only, and so issues no 0x31 and no 0x3F.
- R5: The first page of a cache run is sent as 0x00, the address cycles with column 0, 0x30, a wait for ready, 0x31, a second wait for ready, and then the data of that page.
- R6: Each later page of the run is one command byte, a wait for ready, and then its data. That byte is 0x31 on every such page except the last page of the run, which gets 0x3F. The last page of the run is the start page plus the length shifted right by the page shift.
- R7: With a nonzero column, the start page is read the ordinary way at that column, and the run begins on the next page. Pages needed after the last page of the run are read the ordinary way at column 0.
- R8: On each page the sequencer gives the smaller of two counts of data strobes: the bytes still owed, or the page size minus that page's column. Each strobed byte appears on `out_data` with `out_valid` one cycle later. In total the stream carries exactly the requested bytes, in address order.
- R9: A request of length 0 produces no data strobes and no output bytes. It still sends the command and wait sequence, and it still ends with an `ack` pulse.
- R10: After a command byte that starts a busy period (0x30, 0x31, 0x3F), the bus stays idle for more than `TWB_CYC` cycles. The first strobe of a burst comes at least `TRR_CYC` cycles after ready/busy rises.
- R11: If ready/busy stays low for more than `cfg_timeout` cycles of a wait, the request ends. `ack` pulses with `err` high, and no more bus cycles follow. `err` stays high until the next request is accepted, and that request clears it.
- R12: `ack` is a one-cycle pulse. It comes after the last output byte of the request, and no output byte follows it before the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_page_shift | input | SH_W | log2 of the page size in bytes |
| cfg_row3 | input | 1 | 1: send a fifth address cycle with row bits 23:16 |
| cfg_timeout | input | TMO_W | Longest busy wait in cycles before an abort |
| req_valid | input | 1 | One-cycle request strobe, taken only when idle |
| req_page | input | ROW_W | Start page (row address) |
| req_col | input | COL_W | Column offset inside the start page |
| req_len | input | LEN_W | Byte count to read |
| ack | output | 1 | Pulses once when the request has finished |
| err | output | 1 | High after a timeout abort, until the next request |
| bus_cle | output | 1 | Command cycle on `bus_dout` |
| bus_ale | output | 1 | Address cycle on `bus_dout` |
| bus_re | output | 1 | Data-in strobe, byte taken from `bus_din` |
| bus_dout | output | 8 | Command or address byte |
| bus_din | input | 8 | Data byte from the device |
| bus_rb | input | 1 | Asynchronous ready/busy, high when ready |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |

## Verification
Suppose the page counter or the run boundary is wrong. The device model then switches its cache register to the wrong page, and the very first mismatched byte on `out_data` shows it. A wrong run boundary also shows up at `ack` as a surplus or missing 0x31 or 0x3F, or as an extra 0x00. A wrong byte-remaining count or burst count shows up as a short or long stream, or as `ack` arriving before the final byte. That appears on the page where the count goes wrong. A broken wait timer shows up as bus activity too close after a busy-starting command. It can also show up as an abort with `err` high, or as a request that never ends.

// File: rtl/nand_crd_pkg.sv
// Shared opcodes and state types for the NAND cache-read sequencer.
package nand_crd_pkg;
    localparam logic [7:0] OP_READ  = 8'h00;
    localparam logic [7:0] OP_START = 8'h30;
    localparam logic [7:0] OP_CSEQ  = 8'h31;
    localparam logic [7:0] OP_CEND  = 8'h3F;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PAGE, ST_C00, ST_ADDR, ST_C30, ST_C31, ST_CCONT,
        ST_TWB, ST_WAIT, ST_TRR, ST_DATA, ST_NEXT, ST_DONE
    } crd_state_t;

    typedef enum logic [1:0] {
        PK_ORD, PK_SEQ_FIRST, PK_SEQ_CONT
    } page_kind_t;
endpackage

// File: rtl/nand_crd_sync.sv
// Multi-flop synchronizer for the asynchronous ready/busy line.
// Assumes STAGES >= 2. Resets to "busy", so no wait can pass early.
module nand_crd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // shift the raw level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/nand_crd_planner.sv
// Decides, when a request is accepted, whether it uses the cache flow.
// It also records the first and last pages of the cache run, and
// classifies any current page against that run.
// Assumes the column is smaller than the page size.
module nand_crd_planner
    import nand_crd_pkg::*;
#(
    parameter int ROW_W = 24,
    parameter int COL_W = 16,
    parameter int LEN_W = 20,
    parameter int SH_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ROW_W-1:0] req_page,
    input  logic [COL_W-1:0] req_col,
    input  logic [LEN_W-1:0] req_len,
    input  logic [SH_W-1:0]  cfg_page_shift,
    input  logic [ROW_W-1:0] cur_page,
    output page_kind_t       kind,
    output logic             in_run,
    output logic             is_last
);
    localparam int SUM_W = LEN_W + 2;

    logic             seq_on;
    logic [ROW_W-1:0] run_first;
    logic [ROW_W-1:0] run_last;
    logic [SUM_W-1:0] span, two_pg, three_pg;
    logic             want_seq;

    // geometry test for the cache flow
    always_comb begin
        span     = SUM_W'(req_col) + SUM_W'(req_len);
        two_pg   = SUM_W'(2) << cfg_page_shift;
        three_pg = SUM_W'(3) << cfg_page_shift;
        if (req_col == '0) want_seq = (SUM_W'(req_len) >= two_pg);
        else               want_seq = (span >= three_pg);
    end

    // latch the decision and the run bounds on request accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_on    <= 1'b0;
            run_first <= '0;
            run_last  <= '0;
        end else if (load) begin
            seq_on    <= want_seq;
            run_first <= req_page + ROW_W'(req_col != '0);
            run_last  <= req_page + ROW_W'(req_len >> cfg_page_shift);
        end
    end

    // classify the page being sequenced
    always_comb begin
        in_run  = seq_on && (cur_page >= run_first) && (cur_page <= run_last);
        is_last = (cur_page == run_last);
        if (!in_run)                    kind = PK_ORD;
        else if (cur_page == run_first) kind = PK_SEQ_FIRST;
        else                            kind = PK_SEQ_CONT;
    end
endmodule

// File: rtl/nand_crd_fsm.sv
// Bus sequencer: walks page by page and issues the command and address
// cycles, the timed waits on ready/busy and the data strobes. Bytes it
// strobes are registered onto the output stream.
// Assumes COL_W <= 16, ROW_W <= 24, LEN_W > COL_W, TRR_CYC >= 1, and
// that requests arrive only while the block is idle.
module nand_crd_fsm
    import nand_crd_pkg::*;
#(
    parameter int ROW_W   = 24,
    parameter int COL_W   = 16,
    parameter int LEN_W   = 20,
    parameter int SH_W    = 4,
    parameter int TMO_W   = 16,
    parameter int TWB_TOT = 4,
    parameter int TRR_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SH_W-1:0]  cfg_page_shift,
    input  logic             cfg_row3,
    input  logic [TMO_W-1:0] cfg_timeout,
    input  logic             req_valid,
    input  logic [ROW_W-1:0] req_page,
    input  logic [COL_W-1:0] req_col,
    input  logic [LEN_W-1:0] req_len,
    input  logic             rb_s,
    input  page_kind_t       kind,
    input  logic             in_run,
    input  logic             is_last,
    output logic             plan_load,
    output logic [ROW_W-1:0] cur_page,
    output logic             ack,
    output logic             err,
    output logic             bus_cle,
    output logic             bus_ale,
    output logic             bus_re,
    output logic [7:0]       bus_dout,
    input  logic [7:0]       bus_din,
    output logic             out_valid,
    output logic [7:0]       out_data
);
    localparam int TMAX = (TWB_TOT > TRR_CYC) ? TWB_TOT : TRR_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int BW   = COL_W + 1;

    crd_state_t       state;
    page_kind_t       kind_q;
    logic [COL_W-1:0] pcol;
    logic [LEN_W-1:0] remain;
    logic [BW-1:0]    burst;
    logic [2:0]       aidx;
    logic             after31;
    logic [7:0]       cmd_q;
    logic [TW-1:0]    tcnt;
    logic [TMO_W-1:0] wcnt;
    logic [BW-1:0]    psize, avail;
    logic [2:0]       last_aidx;
    logic [15:0]      col16;
    logic [23:0]      row24;

    assign plan_load = (state == ST_IDLE) && req_valid;
    assign psize     = BW'(1) << cfg_page_shift;
    assign avail     = psize - BW'(pcol);
    assign last_aidx = cfg_row3 ? 3'd4 : 3'd3;
    assign col16     = 16'(pcol);
    assign row24     = 24'(cur_page);

    // main sequencing state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            kind_q   <= PK_ORD;
            cur_page <= '0;
            pcol     <= '0;
            remain   <= '0;
            burst    <= '0;
            aidx     <= '0;
            after31  <= 1'b0;
            cmd_q    <= OP_READ;
            tcnt     <= '0;
            wcnt     <= '0;
            err      <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    cur_page <= req_page;
                    pcol     <= req_col;
                    remain   <= req_len;
                    err      <= 1'b0;
                    state    <= ST_PAGE;
                end
                ST_PAGE: begin
                    kind_q <= kind;
                    if (remain < LEN_W'(avail)) burst <= BW'(remain);
                    else                        burst <= avail;
                    if (kind == PK_SEQ_CONT) begin
                        cmd_q <= is_last ? OP_CEND : OP_CSEQ;
                        state <= ST_CCONT;
                    end else begin
                        aidx  <= '0;
                        state <= ST_C00;
                    end
                end
                ST_C00:  state <= ST_ADDR;
                ST_ADDR: begin
                    if (aidx == last_aidx) state <= ST_C30;
                    else                   aidx  <= aidx + 3'd1;
                end
                ST_C30: begin
                    after31 <= (kind_q == PK_SEQ_FIRST);
                    tcnt    <= '0;
                    state   <= ST_TWB;
                end
                ST_C31, ST_CCONT: begin
                    after31 <= 1'b0;
                    tcnt    <= '0;
                    state   <= ST_TWB;
                end
                ST_TWB: begin
                    if (tcnt == TW'(TWB_TOT - 1)) begin
                        wcnt  <= '0;
                        state <= ST_WAIT;
                    end else begin
                        tcnt <= tcnt + TW'(1);
                    end
                end
                ST_WAIT: begin
                    if (rb_s) begin
                        tcnt <= '0;
                        if (after31)          state <= ST_C31;
                        else if (burst != '0) state <= ST_TRR;
                        else                  state <= ST_NEXT;
                    end else if (wcnt == cfg_timeout) begin
                        err   <= 1'b1;
                        state <= ST_DONE;
                    end else begin
                        wcnt <= wcnt + TMO_W'(1);
                    end
                end
                ST_TRR: begin
                    if (tcnt == TW'(TRR_CYC - 1)) state <= ST_DATA;
                    else                          tcnt  <= tcnt + TW'(1);
                end
                ST_DATA: begin
                    burst  <= burst - BW'(1);
                    remain <= remain - LEN_W'(1);
                    if (burst == BW'(1)) state <= ST_NEXT;
                end
                ST_NEXT: begin
                    if (remain == '0 && (!in_run || is_last)) begin
                        state <= ST_DONE;
                    end else begin
                        cur_page <= cur_page + ROW_W'(1);
                        pcol     <= '0;
                        state    <= ST_PAGE;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // register strobed bytes onto the output stream
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= (state == ST_DATA);
            if (state == ST_DATA) out_data <= bus_din;
        end
    end

    // decode bus cycle type and byte from the current state
    always_comb begin
        bus_cle  = 1'b0;
        bus_ale  = 1'b0;
        bus_re   = (state == ST_DATA);
        bus_dout = 8'h00;
        case (state)
            ST_C00:   begin bus_cle = 1'b1; bus_dout = OP_READ;  end
            ST_C30:   begin bus_cle = 1'b1; bus_dout = OP_START; end
            ST_C31:   begin bus_cle = 1'b1; bus_dout = OP_CSEQ;  end
            ST_CCONT: begin bus_cle = 1'b1; bus_dout = cmd_q;    end
            ST_ADDR: begin
                bus_ale = 1'b1;
                case (aidx)
                    3'd0:    bus_dout = col16[7:0];
                    3'd1:    bus_dout = col16[15:8];
                    3'd2:    bus_dout = row24[7:0];
                    3'd3:    bus_dout = row24[15:8];
                    default: bus_dout = row24[23:16];
                endcase
            end
            default: ;
        endcase
    end

    assign ack = (state == ST_DONE);
endmodule

// File: rtl/nand_crd_top.sv
// Top of the NAND sequential cache-read sequencer. It synchronizes
// ready/busy, plans the read flow from the request geometry and drives
// the byte-wide flash bus. Configuration inputs must hold steady for
// the duration of a request.
module nand_crd_top
    import nand_crd_pkg::*;
#(
    parameter int ROW_W   = 24,
    parameter int COL_W   = 16,
    parameter int LEN_W   = 20,
    parameter int SH_W    = 4,
    parameter int TMO_W   = 16,
    parameter int SYNC_N  = 2,
    parameter int TWB_CYC = 2,
    parameter int TRR_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SH_W-1:0]  cfg_page_shift,
    input  logic             cfg_row3,
    input  logic [TMO_W-1:0] cfg_timeout,
    input  logic             req_valid,
    input  logic [ROW_W-1:0] req_page,
    input  logic [COL_W-1:0] req_col,
    input  logic [LEN_W-1:0] req_len,
    output logic             ack,
    output logic             err,
    output logic             bus_cle,
    output logic             bus_ale,
    output logic             bus_re,
    output logic [7:0]       bus_dout,
    input  logic [7:0]       bus_din,
    input  logic             bus_rb,
    output logic             out_valid,
    output logic [7:0]       out_data
);
    localparam int TWB_TOT = TWB_CYC + SYNC_N;

    logic             rb_s;
    logic             plan_load;
    logic [ROW_W-1:0] cur_page;
    page_kind_t       kind;
    logic             in_run;
    logic             is_last;

    nand_crd_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(bus_rb), .dout(rb_s)
    );

    nand_crd_planner #(
        .ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W), .SH_W(SH_W)
    ) u_plan (
        .clk(clk), .rst_n(rst_n), .load(plan_load),
        .req_page(req_page), .req_col(req_col), .req_len(req_len),
        .cfg_page_shift(cfg_page_shift), .cur_page(cur_page),
        .kind(kind), .in_run(in_run), .is_last(is_last)
    );

    nand_crd_fsm #(
        .ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W), .SH_W(SH_W),
        .TMO_W(TMO_W), .TWB_TOT(TWB_TOT), .TRR_CYC(TRR_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_page_shift(cfg_page_shift),
        .cfg_row3(cfg_row3), .cfg_timeout(cfg_timeout),
        .req_valid(req_valid), .req_page(req_page), .req_col(req_col),
        .req_len(req_len), .rb_s(rb_s), .kind(kind), .in_run(in_run),
        .is_last(is_last), .plan_load(plan_load), .cur_page(cur_page),
        .ack(ack), .err(err), .bus_cle(bus_cle), .bus_ale(bus_ale),
        .bus_re(bus_re), .bus_dout(bus_dout), .bus_din(bus_din),
        .out_valid(out_valid), .out_data(out_data)
    );
endmodule

// File: rtl/nand_crd_chk.sv
// Protocol checker for nand_crd_top, attached through bind below.
module nand_crd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_cle,
    input logic       bus_ale,
    input logic       bus_re,
    input logic [7:0] bus_dout,
    input logic       ack,
    input logic       err,
    input logic       out_valid
);
    // R2
    legal_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cle |-> (bus_dout == 8'h00 || bus_dout == 8'h30 ||
                     bus_dout == 8'h31 || bus_dout == 8'h3F));

    // R2
    one_cycle_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_cle, bus_ale, bus_re}));

    // R8
    strobe_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> out_valid);

    // R8
    no_spurious_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> !out_valid);

    // R12
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R12
    quiet_at_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !(bus_cle || bus_ale || bus_re));

    // R11
    err_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ack);
endmodule

bind nand_crd_top nand_crd_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_cle(bus_cle), .bus_ale(bus_ale),
    .bus_re(bus_re), .bus_dout(bus_dout), .ack(ack), .err(err),
    .out_valid(out_valid)
);

// File: tb/sim_nand_crd_top.sv
// Bench: behavioural flash model with cache and array registers, plus
// sweeps over column and length on small pages.
module sim_nand_crd_top;
    localparam int TWB_CYC = 2;
    localparam int TRR_CYC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_page_shift = 4'd3;
    logic        cfg_row3 = 1'b0;
    logic [15:0] cfg_timeout = 16'd1000;
    logic        req_valid = 1'b0;
    logic [23:0] req_page = '0;
    logic [15:0] req_col = '0;
    logic [19:0] req_len = '0;
    logic        ack, err, bus_cle, bus_ale, bus_re, out_valid;
    logic [7:0]  bus_dout, bus_din, out_data;
    logic        rb_q = 1'b1;
    logic        stuck = 1'b0;
    logic        bus_rb;

    always #2 clk = ~clk;

    nand_crd_top #(.TWB_CYC(TWB_CYC), .TRR_CYC(TRR_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_page_shift(cfg_page_shift),
        .cfg_row3(cfg_row3), .cfg_timeout(cfg_timeout),
        .req_valid(req_valid), .req_page(req_page), .req_col(req_col),
        .req_len(req_len), .ack(ack), .err(err), .bus_cle(bus_cle),
        .bus_ale(bus_ale), .bus_re(bus_re), .bus_dout(bus_dout),
        .bus_din(bus_din), .bus_rb(bus_rb), .out_valid(out_valid),
        .out_data(out_data)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    function automatic logic [7:0] dbyte(input int pg, input int c);
        int v;
        v = (pg * 29) ^ ((pg >> 8) * 7) ^ ((pg >> 16) * 13) ^ (c * 5) ^ (c >> 3);
        return 8'(v + 8'h5A);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // device model and monitor state
    int cyc = 0;
    int opage = 0, ocol = 0, dpage = 0;
    bit pend = 0;
    int busy_cnt = 0, busy_len = 3;
    int acnt = 0;
    int abyte [0:7];
    int n00, n30, n31, n3f, strobes, out_cnt, late_out, data_bad, addr_bad, gap_bad;
    bit ack_seen = 0, err_at_ack = 0;
    bit wcmd_pend = 0;
    int wcmd_cyc = 0, last_evt = 0;
    bit prev_re = 0;
    int exp_acnt = 4;
    int m_start = 0, m_col = 0, m_shift = 3;

    assign bus_rb  = rb_q & ~stuck;
    assign bus_din = dbyte(opage, ocol);

    always @(negedge clk) begin
        cyc++;
        if (pend) begin ocol++; pend = 0; end
        if (busy_cnt > 0) begin
            busy_cnt--;
            if (busy_cnt == 0) begin rb_q = 1'b1; last_evt = cyc; end
        end
        if (rst_n) begin
            if ((bus_cle || bus_ale || bus_re) && wcmd_pend) begin
                if (cyc - wcmd_cyc <= TWB_CYC) gap_bad++;
                wcmd_pend = 0;
            end
            if (bus_cle) begin
                if (bus_dout == 8'h00) begin acnt = 0; n00++; end
                else begin
                    if (bus_dout == 8'h30) begin
                        n30++;
                        if (acnt != exp_acnt) addr_bad++;
                        dpage = abyte[2] | (abyte[3] << 8) | ((acnt == 5) ? (abyte[4] << 16) : 0);
                        opage = dpage;
                        ocol  = abyte[0] | (abyte[1] << 8);
                    end else if (bus_dout == 8'h31) begin
                        n31++; opage = dpage; ocol = 0; dpage++;
                    end else begin
                        n3f++; opage = dpage; ocol = 0;
                    end
                    wcmd_pend = 1; wcmd_cyc = cyc; last_evt = cyc;
                    if (busy_len > 0) begin rb_q = 1'b0; busy_cnt = busy_len; end
                end
            end
            if (bus_ale) begin
                if (acnt < 8) abyte[acnt] = int'(bus_dout);
                acnt++;
            end
            if (bus_re) begin
                if (!prev_re && (cyc - last_evt < TRR_CYC)) gap_bad++;
                pend = 1; strobes++;
            end
            prev_re = bus_re;
            if (out_valid) begin
                if (ack_seen) late_out++;
                else if (out_data != dbyte(m_start + ((m_col + out_cnt) >> m_shift),
                                           (m_col + out_cnt) & ((1 << m_shift) - 1)))
                    data_bad++;
                out_cnt++;
            end
            if (ack) begin ack_seen = 1; err_at_ack = err; end
        end
    end

    task automatic run_req(input int page, input int col, input int len,
                           input int shift, input bit row3, input int busy);
        int p, seq, first, last, need_last, endp, ord, run, e00, e31, e3f, w;
        @(negedge clk); #1;
        if (late_out != 0) chk(0, "R12", late_out, 0);
        cfg_page_shift = 4'(shift); cfg_row3 = row3; busy_len = busy;
        exp_acnt = row3 ? 5 : 4;
        m_start = page; m_col = col; m_shift = shift;
        n00 = 0; n30 = 0; n31 = 0; n3f = 0; strobes = 0; out_cnt = 0;
        late_out = 0; data_bad = 0; addr_bad = 0; gap_bad = 0; ack_seen = 0;
        req_page = 24'(page); req_col = 16'(col); req_len = 20'(len);
        req_valid = 1'b1;
        @(negedge clk); #1;
        req_valid = 1'b0;
        w = 0;
        while (!ack_seen && w < 6000) begin @(negedge clk); #1; w++; end
        chk(ack_seen, "R12 ack arrives", int'(ack_seen), 1);
        repeat (3) @(negedge clk);
        #1;
        p = 1 << shift;
        seq = (col == 0) ? (len >= 2 * p) : (col + len >= 3 * p);
        if (!seq) begin
            e00 = (len == 0) ? 1 : ((col + len - 1) >> shift) + 1;
            e31 = 0; e3f = 0;
        end else begin
            first = page + (col != 0);
            last = page + (len >> shift);
            need_last = page + ((col + len - 1) >> shift);
            endp = (need_last > last) ? need_last : last;
            ord = (col != 0) + (endp - last);
            run = last - first + 1;
            e00 = ord + 1; e31 = run - 1; e3f = 1;
        end
        chk(err_at_ack == 0, "R11 no error on good run", int'(err_at_ack), 0);
        chk((n31 != 0) == (seq != 0), "R4 flow choice", n31, e31);
        chk(n31 == e31 && n3f == e3f, "R6 cache cmd count", n31 * 100 + n3f, e31 * 100 + e3f);
        chk(n00 == e00 && n30 == e00, "R7 ordinary/start count", n00, e00);
        chk(addr_bad == 0, "R3 address cycle count", addr_bad, 0);
        chk(out_cnt == len && data_bad == 0, "R8 data stream", out_cnt * 1000 + data_bad, len * 1000);
        chk(strobes == len, "R8 strobes", strobes, len);
        chk(gap_bad == 0, "R10 timing gaps", gap_bad, 0);
        if (len == 0) chk(strobes == 0 && out_cnt == 0, "R9 zero length", strobes, 0);
        if (seq && col == 0) chk(data_bad == 0 && n00 == 1, "R5 run start page", n00, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!bus_cle && !bus_ale && !bus_re && !ack && !err && !out_valid,
            "R1 in reset", int'({bus_cle, bus_ale, bus_re, ack, err, out_valid}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!bus_cle && !bus_ale && !bus_re && !ack && !err && !out_valid,
            "R1 after reset", int'({bus_cle, bus_ale, bus_re, ack, err, out_valid}), 0);

        // sweep 8-byte pages over every column and many lengths
        for (int c = 0; c < 8; c++)
            for (int l = 0; l <= 26; l++)
                run_req(16'h0100 + c * 3 + l, c, l, 3, 1'b0, l % 5);

        // 16-byte pages with a high row byte (R3 fifth cycle)
        for (int c = 0; c < 16; c += 5)
            for (int l = 0; l <= 60; l += 7)
                run_req(24'h12_3400 + l, c, l, 4, 1'b1, 2);
        run_req(24'h7E_FFFE, 0, 48, 4, 1'b1, 4);
        run_req(24'h00_0010, 15, 33, 4, 1'b1, 0);

        // R11 timeout abort then recovery
        cfg_timeout = 16'd20;
        stuck = 1'b1;
        @(negedge clk); #1;
        ack_seen = 0; out_cnt = 0; strobes = 0;
        req_page = 24'h000200; req_col = 16'd0; req_len = 20'd20; cfg_page_shift = 4'd3;
        cfg_row3 = 1'b0; m_start = 24'h200; m_col = 0; m_shift = 3;
        req_valid = 1'b1;
        @(negedge clk); #1;
        req_valid = 1'b0;
        for (int w = 0; w < 200 && !ack_seen; w++) begin @(negedge clk); #1; end
        chk(ack_seen && err_at_ack, "R11 abort flag", int'(err_at_ack), 1);
        chk(strobes == 0, "R11 no data after abort", strobes, 0);
        n00 = 0; n30 = 0; n31 = 0; n3f = 0;
        repeat (10) @(negedge clk);
        #1;
        chk(err == 1'b1 && (n00 + n30 + n31 + n3f) == 0, "R11 error held, bus idle",
            int'(err), 1);
        stuck = 1'b0;
        cfg_timeout = 16'd1000;
        run_req(24'h000300, 0, 20, 3, 1'b0, 3);
        chk(err == 1'b0, "R11 error cleared", int'(err), 0);

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule